// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block turns single requests from a CPU-side port into timed cycles on an external asynchronous memory bus. Each request carries an address, a direction, an access size (byte or halfword) and, for writes, a 16-bit data word. The block decodes the address into one of four active-low chip selects. It chooses byte-lane strobes from the size and the lowest address bit. It then holds the bus cycle open for a minimum of two clocks, and longer while the external device pulls its wait line low.

Reads use one active-low read strobe and always fetch the full 16-bit word. The requester extracts the byte it needs. Writes use two separate active-low strobes, one per byte lane, so a device can be written one byte at a time without a separate byte-enable bus. The upper two chip selects only reach the pins when the extended-mode input is high. The bus clock output mirrors the controller clock, so one bus clock equals one controller clock.

Top module: `ext_bus_ctrl`

## Requirements
- R1: A read cycle drives rd_n low with wr_hi_n and wr_lo_n both high and db_oe low. req_rdata returns the db_i value present in the last clock of the cycle.
- R2: A write cycle keeps rd_n high. A byte write with req_addr[0]=0 lowers only wr_hi_n (lane bits 15:8), a byte write with req_addr[0]=1 lowers only wr_lo_n (lane bits 7:0), and a halfword write (req_hw=1) lowers both regardless of req_addr[0].
- R3: During every clock of a write cycle db_oe is high and db_o equals the request's req_wdata.
- R4: With wait_n high, a cycle keeps its strobe low for exactly 2 clocks.
- R5: wait_n is sampled from the second clock of the cycle on. Each clock edge at which it is low adds one clock, so N low samples give a cycle of N+2 clocks.
- R6: req_addr[23:22] selects the chip select: value v drives cs_n[v] low and the rest high, for as long as the strobe is low. ext_addr carries req_addr[23:1] during the cycle.
- R7: cs_n[2] and cs_n[3] go low only while ext_mode is 1. With ext_mode at 0, a cycle to regions 2 or 3 still runs, but with all chip selects high.
- R8: Outside a cycle, cs_n is 4'b1111, rd_n, wr_hi_n and wr_lo_n are high, and db_oe is low.
- R9: A request is accepted in the idle state when req_valid is high, and the strobes go low in the next clock. req_ready pulses for one clock right after the last strobe clock. No request is accepted while a cycle runs or while req_ready is high.
- R10: With rst_n low at a clock edge (synchronous, active low), the block returns to idle with the R8 pin levels and req_ready low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | Enables chip selects 2 and 3 |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hw | input | 1 | 1 = halfword, 0 = byte |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 16 | Write data, already placed on its lane |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Word read, valid with req_ready |
| bclk | output | 1 | Bus clock (same as clk) |
| ext_addr | output | 23 | Halfword address req_addr[23:1] |
| cs_n | output | 4 | Active-low chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_hi_n | output | 1 | Active-low upper-lane write strobe |
| wr_lo_n | output | 1 | Active-low lower-lane write strobe |
| db_o | output | 16 | Data bus output value |
| db_oe | output | 1 | Data bus output enable |
| db_i | input | 16 | Data bus input value |
| wait_n | input | 1 | Active-low wait from the device |

## Verification
On every clock, the assertions check these rules: the strobes never conflict with the read strobe, the output enable follows the write strobes, a chip select never shows without a strobe, the gated selects stay high when extended mode is off, a cycle never ends after one clock or while wait is low, and the completion pulse lasts one clock. Other properties need the bench's sweep, because they depend on the request: the exact lane picked for each size and alignment, the region-to-select mapping, the captured address and write data, the total cycle length for a given number of wait samples, and the read word taken in the final clock. The bench sweeps all regions, both modes, both directions, both sizes, both alignments and zero to three wait samples.

// File: rtl/ebi_pkg.sv
// Package: shared types of the external bus sequencer.
// Assumes: strobes are carried active-high inside the block and inverted at the pins.
package ebi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_T1   = 2'd1,
        ST_TW   = 2'd2
    } bus_state_t;

    typedef struct packed {
        logic rd;
        logic wr_hi;
        logic wr_lo;
    } strobe_t;

endpackage

// File: rtl/ebi_decode.sv
// Module: ebi_decode
// Combinational decode of one request into a one-hot chip select and the
// active-high strobe set. Assumes halfword accesses are aligned; bit 0 is
// ignored for them. Upper lane (bits 15:8) belongs to even byte addresses.
module ebi_decode #(
    parameter int ADDR_W = 32,
    parameter int CS_LSB = 22,
    parameter int NCS    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              size_hw,
    output logic [NCS-1:0]    cs_sel,
    output ebi_pkg::strobe_t  strb
);
    localparam int CS_W = $clog2(NCS);

    logic [CS_W-1:0] region;
    assign region = addr[CS_LSB +: CS_W];

    // one comparator per chip select slot
    generate
        for (genvar i = 0; i < NCS; i++) begin : g_cs
            assign cs_sel[i] = (region == CS_W'(i));
        end
    endgenerate

    // lane choice from direction, size and alignment
    always_comb begin
        strb.rd    = !write;
        strb.wr_hi = write && (size_hw || !addr[0]);
        strb.wr_lo = write && (size_hw ||  addr[0]);
    end

endmodule

// File: rtl/ebi_seq.sv
// Module: ebi_seq
// Cycle sequencer: idle -> first clock -> wait clocks until wait_n is seen
// high. The first clock never samples wait_n, which gives the built-in wait.
// Assumes wait_n is already synchronous to clk.
module ebi_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic wait_n,
    output logic accept,
    output logic done,
    output logic ready
);
    import ebi_pkg::*;

    bus_state_t state_q;
    logic       ready_q;

    // accept only when idle and not in the completion-pulse clock
    assign accept = (state_q == ST_IDLE) && req_valid && !ready_q;
    assign done   = (state_q == ST_TW) && wait_n;
    assign ready  = ready_q;

    // state register and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b0;
        end else begin
            ready_q <= done;
            case (state_q)
                ST_IDLE: if (accept) state_q <= ST_T1;
                ST_T1:   state_q <= ST_TW;
                ST_TW:   if (wait_n) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ebi_dpath.sv
// Module: ebi_dpath
// Holds the address, chip select, strobes and write data of the running cycle,
// and captures the read word at the completing edge. Assumes accept and done
// never fall in the same clock (guaranteed by ebi_seq).
module ebi_dpath #(
    parameter int ADDR_W = 32,
    parameter int EXT_AW = 23,
    parameter int DATA_W = 16,
    parameter int NCS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              done,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [NCS-1:0]    cs_sel,
    input  ebi_pkg::strobe_t  strb,
    input  logic [DATA_W-1:0] db_i,
    output logic [EXT_AW-1:0] addr_q,
    output logic [NCS-1:0]    cs_q,
    output ebi_pkg::strobe_t  strb_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              oe_q,
    output logic [DATA_W-1:0] rdata_q
);
    // address and write data are loaded per request and held afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr[EXT_AW:1];
            wdata_q <= req_wdata;
        end
    end

    // cycle controls: set on accept, cleared when the cycle completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= '0;
            strb_q <= '0;
            oe_q   <= 1'b0;
        end else if (accept) begin
            cs_q   <= cs_sel;
            strb_q <= strb;
            oe_q   <= strb.wr_hi || strb.wr_lo;
        end else if (done) begin
            cs_q   <= '0;
            strb_q <= '0;
            oe_q   <= 1'b0;
        end
    end

    // read word captured at the completing edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (done && strb_q.rd) begin
            rdata_q <= db_i;
        end
    end

endmodule

// File: rtl/ext_bus_ctrl.sv
// Module: ext_bus_ctrl (top)
// External bus sequencer with separate per-lane write strobes. One request at
// a time; the bus clock equals clk. Assumes the requester holds its request
// stable until req_ready. Chip selects at index NCS_BASE and above are gated
// by ext_mode.
module ext_bus_ctrl #(
    parameter int ADDR_W   = 32,
    parameter int EXT_AW   = 23,
    parameter int DATA_W   = 16,
    parameter int NCS      = 4,
    parameter int NCS_BASE = 2,
    parameter int CS_LSB   = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_hw,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic              bclk,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [NCS-1:0]    cs_n,
    output logic              rd_n,
    output logic              wr_hi_n,
    output logic              wr_lo_n,
    output logic [DATA_W-1:0] db_o,
    output logic              db_oe,
    input  logic [DATA_W-1:0] db_i,
    input  logic              wait_n
);
    import ebi_pkg::*;

    logic [NCS-1:0] cs_sel;
    strobe_t        strb;
    logic           accept;
    logic           done;
    logic [NCS-1:0] cs_q;
    strobe_t        strb_q;

    ebi_decode #(.ADDR_W(ADDR_W), .CS_LSB(CS_LSB), .NCS(NCS)) u_decode (
        .addr    (req_addr),
        .write   (req_write),
        .size_hw (req_hw),
        .cs_sel  (cs_sel),
        .strb    (strb)
    );

    ebi_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .wait_n    (wait_n),
        .accept    (accept),
        .done      (done),
        .ready     (req_ready)
    );

    ebi_dpath #(.ADDR_W(ADDR_W), .EXT_AW(EXT_AW), .DATA_W(DATA_W), .NCS(NCS)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .done      (done),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cs_sel    (cs_sel),
        .strb      (strb),
        .db_i      (db_i),
        .addr_q    (ext_addr),
        .cs_q      (cs_q),
        .strb_q    (strb_q),
        .wdata_q   (db_o),
        .oe_q      (db_oe),
        .rdata_q   (req_rdata)
    );

    // pin drivers: selects, gated above NCS_BASE by the extended mode
    generate
        for (genvar i = 0; i < NCS; i++) begin : g_csn
            if (i < NCS_BASE) begin : g_plain
                assign cs_n[i] = !cs_q[i];
            end else begin : g_gated
                assign cs_n[i] = !(cs_q[i] && ext_mode);
            end
        end
    endgenerate

    assign rd_n    = !strb_q.rd;
    assign wr_hi_n = !strb_q.wr_hi;
    assign wr_lo_n = !strb_q.wr_lo;
    assign bclk    = clk;

endmodule

// File: rtl/ext_bus_ctrl_chk.sv
// Module: ext_bus_ctrl_chk
// Pin-level protocol checker bound to ext_bus_ctrl.
module ext_bus_ctrl_chk #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ext_mode,
    input logic           req_ready,
    input logic [NCS-1:0] cs_n,
    input logic           rd_n,
    input logic           wr_hi_n,
    input logic           wr_lo_n,
    input logic           db_oe,
    input logic           wait_n
);
    logic act;
    assign act = !rd_n || !wr_hi_n || !wr_lo_n;

    p_read_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (wr_hi_n && wr_lo_n && !db_oe));

    p_write_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hi_n || !wr_lo_n) |-> db_oe);

    p_min_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !$past(act)) |=> act);

    p_wait_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !wait_n) |=> act);

    p_cs_in_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~cs_n) != 0) |-> act);

    p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_gated_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> (cs_n[NCS-1:2] == '1));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> (!db_oe && cs_n == '1));

    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

endmodule

bind ext_bus_ctrl ext_bus_ctrl_chk #(.NCS(NCS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_mode  (ext_mode),
    .req_ready (req_ready),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_hi_n   (wr_hi_n),
    .wr_lo_n   (wr_lo_n),
    .db_oe     (db_oe),
    .wait_n    (wait_n)
);

// File: tb/ext_bus_ctrl_bench.sv
`timescale 1ns/1ps
module ext_bus_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_hw = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic [15:0] req_rdata;
    logic        bclk;
    logic [22:0] ext_addr;
    logic [3:0]  cs_n;
    logic        rd_n, wr_hi_n, wr_lo_n;
    logic [15:0] db_o;
    logic        db_oe;
    logic [15:0] db_i = '0;
    logic        wait_n = 1'b1;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #4 clk = !clk;

    ext_bus_ctrl u_ext_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .req_valid(req_valid),
        .req_write(req_write), .req_hw(req_hw), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
        .bclk(bclk), .ext_addr(ext_addr), .cs_n(cs_n), .rd_n(rd_n),
        .wr_hi_n(wr_hi_n), .wr_lo_n(wr_lo_n), .db_o(db_o), .db_oe(db_oe),
        .db_i(db_i), .wait_n(wait_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // idle pin levels (R8)
    task automatic chk_idle(input string tag);
        chk(tag, {cs_n, rd_n, wr_hi_n, wr_lo_n, db_oe}, {4'hF, 1'b1, 1'b1, 1'b1, 1'b0});
    endtask

    function automatic logic [15:0] rd_pat(input int idx, input int k);
        return 16'h3C00 ^ 16'(idx << 4) ^ 16'(k);
    endfunction

    task automatic run_txn(input int r, input int em, input int wr, input int hw,
                           input int a0, input int nw, input int idx);
        logic [31:0] a;
        logic [15:0] wd;
        logic [3:0]  exp_cs;
        logic        e_hi, e_lo;
        int          k;
        a  = (32'(r) << 22) | ((32'(idx) * 32'h246) & 32'h003F_FFFE) | 32'(a0);
        wd = 16'hA5C3 ^ 16'(idx * 16'h1357);
        exp_cs = (r >= 2 && em == 0) ? 4'hF : ~(4'b0001 << r);
        e_hi = (wr != 0) && (hw != 0 || a0 == 0);
        e_lo = (wr != 0) && (hw != 0 || a0 == 1);
        @(negedge clk);
        ext_mode  = em[0];
        req_write = wr[0];
        req_hw    = hw[0];
        req_addr  = a;
        req_wdata = wd;
        req_valid = 1'b1;
        wait_n    = 1'b1;
        @(negedge clk);
        k = 0;
        while (k < 20 && (!rd_n || !wr_hi_n || !wr_lo_n)) begin
            chk("R6/R7 cs_n", 32'(cs_n), 32'(exp_cs));
            chk("R6 ext_addr", 32'(ext_addr), 32'(a[23:1]));
            chk("R1/R2 rd_n", 32'(rd_n), 32'(wr != 0));
            chk("R2 wr_hi_n", 32'(wr_hi_n), 32'(!e_hi));
            chk("R2 wr_lo_n", 32'(wr_lo_n), 32'(!e_lo));
            chk("R1/R3 db_oe", 32'(db_oe), 32'(wr != 0));
            if (wr != 0) chk("R3 db_o", 32'(db_o), 32'(wd));
            chk("R9 ready low in cycle", 32'(req_ready), 32'd0);
            wait_n = (k >= 1 && k <= nw) ? 1'b0 : 1'b1;
            db_i   = rd_pat(idx, k);
            k++;
            @(negedge clk);
        end
        if (nw == 0) chk("R4 length", 32'(k), 32'(nw + 2));
        else         chk("R5 length", 32'(k), 32'(nw + 2));
        chk("R9 ready pulse", 32'(req_ready), 32'd1);
        if (wr == 0) chk("R1 rdata", 32'(req_rdata), 32'(rd_pat(idx, nw + 1)));
        req_valid = 1'b0;
        wait_n    = 1'b1;
        @(negedge clk);
        chk("R9 ready one clock", 32'(req_ready), 32'd0);
        chk_idle("R8/R9 idle, no re-accept");
    endtask

    initial begin
        int idx;
        idx = 0;
        repeat (3) @(negedge clk);
        chk_idle("R10 reset pins");
        chk("R10 reset ready", 32'(req_ready), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R8 idle after reset");
        for (int r = 0; r < 4; r++)
            for (int em = 0; em < 2; em++)
                for (int wr = 0; wr < 2; wr++)
                    for (int hw = 0; hw < 2; hw++)
                        for (int a0 = 0; a0 < 2; a0++)
                            for (int nw = 0; nw < 4; nw++) begin
                                run_txn(r, em, wr, hw, a0, nw, idx);
                                idx++;
                            end
        // reset in the middle of a long cycle
        @(negedge clk);
        req_write = 1'b1; req_hw = 1'b1; req_addr = 32'h0040_0010; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; wait_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_idle("R10 reset mid-cycle");
        rst_n = 1'b1; wait_n = 1'b1;
        @(negedge clk);
        chk_idle("R10 idle after mid-cycle reset");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule